// File: doc/BRIEF.md
# Soft-Output Hypothesis List Manager

This block holds the running result list of a single-pass soft-output tree search. The list has three parts: the label of the best leaf found so far, that leaf's metric, and one alternative-hypothesis metric for each label bit. The datapath reports each leaf it reaches as a label of `NSTREAM*BPS` bits and an unsigned distance. For every leaf, the block updates the list in one clock cycle. It also caps the alternative metrics at the best metric plus a clipping level.

When the search ends, a finish strobe makes the block produce one signed soft value per label bit, one cycle later. The magnitude is the distance between the alternative metric and the best metric. The sign comes from the best label's bit. A start strobe clears the list before each new symbol vector. Metrics are unsigned fixed point. The all-ones code stands for infinity, and every sum saturates at that code.

Top module: `soft_hyp_list`

## Requirements
- R1: After reset or a start strobe, the best metric and every alternative metric equal the infinity code `2^MW-1`, and the best label is all zeros. The soft outputs are zero and `soft_vld_o` is low after reset.
- R2: For a leaf whose distance d is strictly below the best metric, every bit where the leaf label differs from the best label first takes the old best metric as its alternative metric. The best metric then becomes d and the best label becomes the leaf label.
- R3: For a leaf whose distance d is equal to or above the best metric, an alternative metric is replaced by d only when two conditions hold: the leaf label differs from the best label at that bit, and the stored metric exceeds d. All other alternative metrics and the best entry keep their values.
- R4: In the same cycle as a best-metric update, every alternative metric is limited to the smaller of itself and the saturated sum d + `lmax_i`.
- R5: Each soft value is `MW+1` bits, two's complement, and bit k sits at `soft_o[k*(MW+1) +: MW+1]`. Its magnitude is the alternative metric minus the best metric. It is positive when the best-label bit is 1 and negative when that bit is 0.
- R6: A bit whose alternative metric is still the infinity code at finish outputs magnitude `lmax_i`.
- R7: With `lmax_i` = 0 held through a search, every soft value is zero.
- R8: The clipping sum saturates at the infinity code and never wraps. An alternative metric clipped to that code therefore reports `lmax_i` at finish.
- R9: A leaf strobe in the same cycle as start is ignored, and the list is left cleared.
- R10: `soft_vld_o` is a one-cycle pulse in the cycle after `finish_i`. `soft_o` holds its value until the next finish.

`lmax_i` is held constant from start to finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the list |
| leaf_vld_i | input | 1 | Leaf event strobe |
| leaf_lbl_i | input | NSTREAM*BPS | Leaf label |
| leaf_dist_i | input | MW | Leaf distance |
| lmax_i | input | MW | Clipping level |
| finish_i | input | 1 | End of search |
| soft_o | output | NSTREAM*BPS*(MW+1) | Signed soft values |
| soft_vld_o | output | 1 | Soft values valid pulse |

## Verification
A wrong alternative metric in any slot stays hidden until the next finish. It then shows up as a wrong magnitude for that bit alone, one cycle after the strobe. A wrong best label flips the sign of the affected bits. A wrong best metric shifts every magnitude by the same amount. The bench runs a reference list next to the design and compares every bit at each finish. It uses directed leaf orders that reach the replace, flip, tie, clip and saturation paths, as well as random searches.

// File: rtl/hlm_pkg.sv
package hlm_pkg;
   function automatic logic [31:0] sat_add32(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] lim);
      logic [32:0] s;
      s = {1'b0, a} + {1'b0, b};
      return (s >= {1'b0, lim}) ? lim : s[31:0];
   endfunction
endpackage

// File: rtl/hlm_cnt_slot.sv
module hlm_cnt_slot #(
   parameter int MW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          upd_i,
   input  logic          better_i,
   input  logic          flip_i,
   input  logic [MW-1:0] dist_i,
   input  logic [MW-1:0] old_best_i,
   input  logic [MW-1:0] clip_i,
   output logic [MW-1:0] metric_o
);
   localparam logic [MW-1:0] INF = '1;

   logic [MW-1:0] met_q, met_d, seed;

   always_comb begin
      seed  = flip_i ? old_best_i : met_q;
      met_d = met_q;
      if (clr_i) begin
         met_d = INF;
      end else if (upd_i) begin
         if (better_i) begin
            met_d = (seed < clip_i) ? seed : clip_i;
         end else if (flip_i && (dist_i < met_q)) begin
            met_d = dist_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) met_q <= INF;
      else        met_q <= met_d;
   end

   assign metric_o = met_q;

   p_clr_inf_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> metric_o == INF);
   p_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && better_i && !clr_i) |=> metric_o <= $past(clip_i));
   p_no_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> metric_o <= $past(metric_o));
endmodule

// File: rtl/hlm_soft_map.sv
module hlm_soft_map #(
   parameter int MW          = 12,
   parameter bit ONE_IS_POS  = 1'b1
) (
   input  logic [MW-1:0] cnt_i,
   input  logic [MW-1:0] best_i,
   input  logic          bit_i,
   input  logic [MW-1:0] lmax_i,
   output logic [MW:0]   soft_o
);
   localparam logic [MW-1:0] INF = '1;

   logic [MW-1:0] mag;
   logic          pos;

   assign mag = (cnt_i == INF) ? lmax_i : (cnt_i - best_i);

   generate
      if (ONE_IS_POS) begin : g_pos_one
         assign pos = bit_i;
      end else begin : g_pos_zero
         assign pos = ~bit_i;
      end
   endgenerate

   assign soft_o = pos ? {1'b0, mag} : (~{1'b0, mag} + 1'b1);
endmodule

// File: rtl/soft_hyp_list.sv
module soft_hyp_list #(
   parameter int NSTREAM    = 4,
   parameter int BPS        = 4,
   parameter int MW         = 12,
   parameter bit ONE_IS_POS = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic                        leaf_vld_i,
   input  logic [NSTREAM*BPS-1:0]      leaf_lbl_i,
   input  logic [MW-1:0]               leaf_dist_i,
   input  logic [MW-1:0]               lmax_i,
   input  logic                        finish_i,
   output logic [NSTREAM*BPS*(MW+1)-1:0] soft_o,
   output logic                        soft_vld_o
);
   import hlm_pkg::*;

   localparam int NB = NSTREAM * BPS;
   localparam int SW = MW + 1;
   localparam logic [MW-1:0] INF = '1;

   initial begin
      assert (NSTREAM >= 1) else $error("NSTREAM must be at least 1");
      assert (BPS >= 1)     else $error("BPS must be at least 1");
      assert (MW >= 2 && MW <= 31) else $error("MW out of range");
   end

   logic [MW-1:0] best_q;
   logic [NB-1:0] best_lbl_q;
   logic          upd, better;
   logic [NB-1:0] flip;
   logic [MW-1:0] clip_lim;
   logic [31:0]   clip_wide;
   logic [MW-1:0] cnt [NB];
   logic [NB*SW-1:0] soft_c, soft_q;
   logic          vld_q;

   assign upd       = leaf_vld_i && !start_i;
   assign better    = upd && (leaf_dist_i < best_q);
   assign flip      = leaf_lbl_i ^ best_lbl_q;
   assign clip_wide = sat_add32(32'(leaf_dist_i), 32'(lmax_i), 32'(INF));
   assign clip_lim  = clip_wide[MW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_q     <= INF;
         best_lbl_q <= '0;
      end else if (start_i) begin
         best_q     <= INF;
         best_lbl_q <= '0;
      end else if (better) begin
         best_q     <= leaf_dist_i;
         best_lbl_q <= leaf_lbl_i;
      end
   end

   generate
      for (genvar k = 0; k < NB; k++) begin : g_slot
         hlm_cnt_slot #(.MW(MW)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (start_i),
            .upd_i      (upd),
            .better_i   (better),
            .flip_i     (flip[k]),
            .dist_i     (leaf_dist_i),
            .old_best_i (best_q),
            .clip_i     (clip_lim),
            .metric_o   (cnt[k])
         );
         hlm_soft_map #(.MW(MW), .ONE_IS_POS(ONE_IS_POS)) i_map (
            .cnt_i  (cnt[k]),
            .best_i (best_q),
            .bit_i  (best_lbl_q[k]),
            .lmax_i (lmax_i),
            .soft_o (soft_c[k*SW +: SW])
         );
         p_cnt_ge_best_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[k] >= best_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= finish_i;
         if (finish_i) soft_q <= soft_c;
      end
   end

   assign soft_o     = soft_q;
   assign soft_vld_o = vld_q;

   p_best_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> best_q <= $past(best_q));
   p_start_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (best_q == INF) && (best_lbl_q == '0));
   p_vld_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      finish_i |=> soft_vld_o);
   p_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !finish_i |=> !soft_vld_o);
   p_sat_nowrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      leaf_vld_i |-> (clip_lim >= leaf_dist_i) && (clip_lim >= lmax_i));
endmodule

// File: tb/test_soft_hyp_list.sv
module test_soft_hyp_list;
   localparam int NSTREAM = 4;
   localparam int BPS     = 4;
   localparam int MW      = 12;
   localparam int NB      = NSTREAM * BPS;
   localparam int SW      = MW + 1;
   localparam int INF     = (1 << MW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              leaf_vld_i = 1'b0;
   logic [NB-1:0]     leaf_lbl_i = '0;
   logic [MW-1:0]     leaf_dist_i = '0;
   logic [MW-1:0]     lmax_i = '0;
   logic              finish_i = 1'b0;
   logic [NB*SW-1:0]  soft_o;
   logic              soft_vld_o;

   soft_hyp_list i_soft_hyp_list (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .leaf_vld_i(leaf_vld_i),
      .leaf_lbl_i(leaf_lbl_i), .leaf_dist_i(leaf_dist_i), .lmax_i(lmax_i),
      .finish_i(finish_i), .soft_o(soft_o), .soft_vld_o(soft_vld_o)
   );

   always #2 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int        m_best;
   bit [NB-1:0] m_lbl;
   int        m_cnt [NB];
   int        m_lmax;

   logic [NB*SW-1:0] exp_q [$];
   string            tag_q [$];
   logic [NB*SW-1:0] last_exp = '0;
   bit               prev_vld = 1'b0;

   function automatic void m_clear();
      m_best = INF;
      m_lbl  = '0;
      for (int k = 0; k < NB; k++) m_cnt[k] = INF;
   endfunction

   function automatic void m_leaf(input bit [NB-1:0] lbl, input int d);
      int lim;
      if (d < m_best) begin
         for (int k = 0; k < NB; k++) if (lbl[k] != m_lbl[k]) m_cnt[k] = m_best;
         m_best = d;
         m_lbl  = lbl;
         lim = d + m_lmax;
         if (lim > INF) lim = INF;
         for (int k = 0; k < NB; k++) if (m_cnt[k] > lim) m_cnt[k] = lim;
      end else begin
         for (int k = 0; k < NB; k++)
            if (lbl[k] != m_lbl[k] && d < m_cnt[k]) m_cnt[k] = d;
      end
   endfunction

   function automatic logic [NB*SW-1:0] m_soft();
      logic [NB*SW-1:0] v;
      int mag;
      for (int k = 0; k < NB; k++) begin
         mag = (m_cnt[k] == INF) ? m_lmax : (m_cnt[k] - m_best);
         v[k*SW +: SW] = m_lbl[k] ? SW'(mag) : SW'(-mag);
      end
      return v;
   endfunction

   task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp,
                        input int bitno);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s bit %0d: actual %0d expected %0d", tag, bitno,
                  $signed(act), $signed(exp));
      end
   endtask

   task automatic do_start(input int lm);
      @(negedge clk);
      start_i = 1'b1; lmax_i = MW'(lm); m_lmax = lm;
      m_clear();
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic do_leaf(input bit [NB-1:0] lbl, input int d);
      @(negedge clk);
      leaf_vld_i = 1'b1; leaf_lbl_i = lbl; leaf_dist_i = MW'(d);
      m_leaf(lbl, d);
      @(negedge clk);
      leaf_vld_i = 1'b0;
   endtask

   task automatic do_finish(input string tag);
      @(negedge clk);
      finish_i = 1'b1;
      exp_q.push_back(m_soft());
      tag_q.push_back(tag);
      @(negedge clk);
      finish_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_vld && !soft_vld_o) begin
            // R10: pulse lasts one cycle and the vector holds
            n_run++;
            if (soft_o !== last_exp) begin
               n_fail++;
               $display("FAIL R10 hold: actual %h expected %h", soft_o, last_exp);
            end
         end
         if (soft_vld_o) begin
            if (exp_q.size() == 0) begin
               n_run++; n_fail++;
               $display("FAIL R10 unexpected valid: actual 1 expected 0");
            end else begin
               logic [NB*SW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               last_exp = e;
               for (int k = 0; k < NB; k++) check(t, soft_o[k*SW +: SW], e[k*SW +: SW], k);
            end
         end
         prev_vld <= soft_vld_o;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      m_lmax = 0;
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      n_run++;
      if (soft_vld_o !== 1'b0 || soft_o !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: actual vld %b soft %h expected 0 0", soft_vld_o, soft_o);
      end

      // R1 R6: no leaves, all infinity -> -Lmax
      lmax_i = MW'(50); m_lmax = 50;
      do_finish("R1_R6_empty");

      // R2 R4: first leaf, then better leaf flipping bits
      do_start(100);
      do_leaf(16'h00F0, 500);
      do_finish("R4_first_leaf");
      do_leaf(16'h0F00, 300);
      do_finish("R2_new_best");
      // R3: worse leaf lowers flipped slots only, tie counts as worse
      do_leaf(16'h0F01, 350);
      do_leaf(16'h8F00, 300);
      do_leaf(16'h0F10, 390);
      do_finish("R3_counter");
      do_leaf(16'h1234, 120);
      do_finish("R2_R4_second_best");

      // R7: zero clip level
      do_start(0);
      do_leaf(16'hA5A5, 700);
      do_leaf(16'h5A5A, 650);
      do_leaf(16'hFFFF, 900);
      do_finish("R7_zero_lmax");

      // R8: clip sum saturates
      do_start(4000);
      do_leaf(16'h0003, 3000);
      do_finish("R8_saturate");
      do_leaf(16'h0001, 3500);
      do_finish("R8_R6_after_saturate");

      // R9: leaf with start is ignored
      do_start(200);
      do_leaf(16'h00FF, 40);
      @(negedge clk);
      start_i = 1'b1; leaf_vld_i = 1'b1; leaf_lbl_i = 16'hFFFF; leaf_dist_i = MW'(10);
      m_clear();
      @(negedge clk);
      start_i = 1'b0; leaf_vld_i = 1'b0;
      do_finish("R9_start_priority");

      // R5: random searches against reference list
      for (int s = 0; s < 40; s++) begin
         int lm;
         int nl;
         case (s % 4)
            0: lm = 7;
            1: lm = 300;
            2: lm = 0;
            default: lm = int'($urandom_range(1, 4095));
         endcase
         do_start(lm);
         nl = int'($urandom_range(1, 10));
         for (int j = 0; j < nl; j++)
            do_leaf(NB'($urandom), int'($urandom_range(0, 4094)));
         do_finish("R5_random");
      end

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_run++; n_fail++;
         $display("FAIL R10 missing valid: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule